// File: doc/BRIEF.md
# Ethernet DMA Halfword Byte-Swap Path

This block sits between the DMA request side of a 16-bit Ethernet controller and a byte-addressed memory port. The controller hands over one request at a time: a device-relative byte address, a byte length, a direction (into memory or out of it) and a flag that bypasses swapping. The memory address is formed by a bitwise OR of the request address with a base value supplied by the control block, not by an addition.

In swap mode the two bytes of every 16-bit halfword are exchanged in both directions. Bit 0 of the address and of the length is cleared before the transfer starts. Writes into memory are cut into bursts of at most `CHUNK_BYTES` bytes, with one idle cycle between bursts, and each burst carries on from where the previous one ended. In bypass mode the data, the address and the length pass through untouched. The memory port moves one halfword per beat over a valid/ready handshake.

The controller (`ethdma_swap_ctl`) has four states. `ST_IDLE` waits for a request. `ST_MOVE` presents beats. `ST_GAP` is the one idle cycle between write chunks. `ST_DONE` raises the done strobe. The transitions are:
- IDLE→MOVE on a request whose effective length is non-zero.
- IDLE→DONE on a request whose effective length is zero.
- MOVE→GAP on the accepted last beat of a chunk that is not the last beat of the transfer.
- GAP→MOVE unconditionally.
- MOVE→DONE on the accepted final beat.
- DONE→IDLE unconditionally.

Top module: `ethdma_swap_path`

## Requirements
- R1: The first beat address is `req_addr | base_addr`, with bit 0 cleared in swap mode. Each accepted beat advances the address by 2, and this includes the step across a chunk gap.
- R2: With `req_bypass`=1 the address and length are used exactly as given and data is not modified. The last beat of an odd length has `mem_be`=2'b01, where bit 0 enables the byte at `mem_addr` (data[7:0]) and bit 1 enables the byte at `mem_addr+1` (data[15:8]). Every other beat has `mem_be`=2'b11.
- R3: With `req_bypass`=0, bit 0 of the address and bit 0 of the length are cleared before the transfer, so every beat is even-addressed with `mem_be`=2'b11.
- R4: With `req_bypass`=0, memory writes carry `{dev_wdata[7:0], dev_wdata[15:8]}`, and read data is returned as `{mem_rdata[7:0], mem_rdata[15:8]}` on `dev_rdata`.
- R5: Swapped writes form bursts of at most `CHUNK_BYTES` bytes. `mem_last` is set on the final beat of each burst, and exactly one cycle with `mem_valid` low separates two bursts. Reads and bypass writes form a single burst.
- R6: A request whose effective length is zero causes no memory beat, and `done` is high in the cycle after acceptance.
- R7: `done` is high for exactly one cycle, in the cycle after the final accepted beat. `busy` is high from the cycle after acceptance through the `done` cycle, and low otherwise.
- R8: `req_valid` is ignored while `busy` is high.
- R9: While `mem_valid` is high and `mem_ready` is low, the beat is held with the same address. `dev_wtake` and `dev_rvalid` pulse only on accepted write beats and read beats respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | AW | Base value ORed into the address |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | AW | Device-relative byte address |
| req_len | input | LW | Byte length |
| req_write | input | 1 | 1 = into memory, 0 = out of memory |
| req_bypass | input | 1 | 1 = no swap, no even-forcing, no chunking |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| dev_wdata | input | 16 | Halfword from the Ethernet controller for the current write beat |
| dev_wtake | output | 1 | Current write halfword consumed |
| dev_rdata | output | 16 | Halfword returned to the Ethernet controller |
| dev_rvalid | output | 1 | dev_rdata valid |
| mem_valid | output | 1 | Beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat direction |
| mem_addr | output | AW | Byte address of the beat |
| mem_be | output | 2 | Byte enables per lane |
| mem_last | output | 1 | Last beat of the burst |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid on an accepted read beat |

## Verification
The two functions that can fall in the same cycle are the end of a write chunk and the end of the whole transfer. When a swapped write length is a multiple of the chunk size, the final beat is both, and the controller must go to DONE rather than GAP. The sweep provokes this with lengths of exactly one and two chunks, alongside lengths one halfword past a chunk boundary. It judges the outcome by requiring `done` in the cycle after the final beat, with no gap cycle and no further beat. The run also keeps `req_valid` asserted with conflicting fields throughout some transfers, so that a request arriving during busy coincides with beats and with the done cycle.

// File: rtl/ethdma_swap_pkg.sv
package ethdma_swap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_GAP,
        ST_DONE
    } xfer_state_e;
endpackage

// File: rtl/ethdma_swap_former.sv
module ethdma_swap_former #(
    parameter int AW = 32,
    parameter int LW = 12
) (
    input  logic [AW-1:0] dev_addr,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic          bypass,
    output logic [AW-1:0] eff_addr,
    output logic [LW-1:0] eff_len
);
    logic [AW-1:0] merged;

    always_comb begin
        merged   = dev_addr | base;
        eff_addr = merged;
        eff_len  = len;
        if (!bypass) begin
            eff_addr[0] = 1'b0;
            eff_len[0]  = 1'b0;
        end
    end
endmodule

// File: rtl/ethdma_swap_lane.sv
module ethdma_swap_lane (
    input  logic [15:0] din,
    input  logic        swap_en,
    output logic [15:0] dout
);
    always_comb begin
        dout = swap_en ? {din[7:0], din[15:8]} : din;
    end
endmodule

// File: rtl/ethdma_swap_ctl.sv
module ethdma_swap_ctl
    import ethdma_swap_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 12,
    parameter int CHUNK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] start_len,
    input  logic          start_we,
    input  logic          start_swap,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic          mem_last,
    output logic          we_q,
    output logic          swap_q,
    output logic          busy,
    output logic          done
);
    localparam int CW = $clog2(CHUNK_BYTES) + 1;

    xfer_state_e   state, nxt;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic [CW-1:0] cbytes_q;
    logic          last_all;
    logic          chunk_end;
    logic          beat;
    logic          accept;

    assign accept    = start_req && (state == ST_IDLE);
    assign beat      = (state == ST_MOVE) && mem_ready;
    assign last_all  = (rem_q <= LW'(2));
    assign chunk_end = swap_q && we_q &&
                       (({1'b0, cbytes_q} + (CW+1)'(2)) == (CW+1)'(CHUNK_BYTES));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) nxt = (start_len == '0) ? ST_DONE : ST_MOVE;
            ST_MOVE: if (beat) begin
                if (last_all)       nxt = ST_DONE;
                else if (chunk_end) nxt = ST_GAP;
            end
            ST_GAP:  nxt = ST_MOVE;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // transfer bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rem_q    <= '0;
            cbytes_q <= '0;
            we_q     <= 1'b0;
            swap_q   <= 1'b0;
        end else if (accept) begin
            addr_q   <= start_addr;
            rem_q    <= start_len;
            cbytes_q <= '0;
            we_q     <= start_we;
            swap_q   <= start_swap;
        end else if (beat) begin
            addr_q   <= addr_q + AW'(2);
            rem_q    <= (rem_q == LW'(1)) ? '0 : rem_q - LW'(2);
            cbytes_q <= chunk_end ? '0 : cbytes_q + CW'(2);
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        mem_valid = (state == ST_MOVE);
        mem_addr  = addr_q;
        mem_be    = (rem_q == LW'(1)) ? 2'b01 : 2'b11;
        mem_last  = last_all || chunk_end;
    end
endmodule

// File: rtl/ethdma_swap_path.sv
module ethdma_swap_path #(
    parameter int AW          = 32,
    parameter int LW          = 12,
    parameter int CHUNK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_write,
    input  logic          req_bypass,
    output logic          busy,
    output logic          done,
    input  logic [15:0]   dev_wdata,
    output logic          dev_wtake,
    output logic [15:0]   dev_rdata,
    output logic          dev_rvalid,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic          mem_last,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);
    logic [AW-1:0] eff_addr;
    logic [LW-1:0] eff_len;
    logic          swap_q;

    ethdma_swap_former #(.AW(AW), .LW(LW)) u_former (
        .dev_addr (req_addr),
        .base     (base_addr),
        .len      (req_len),
        .bypass   (req_bypass),
        .eff_addr (eff_addr),
        .eff_len  (eff_len)
    );

    ethdma_swap_ctl #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (req_valid),
        .start_addr (eff_addr),
        .start_len  (eff_len),
        .start_we   (req_write),
        .start_swap (!req_bypass),
        .mem_ready  (mem_ready),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_last   (mem_last),
        .we_q       (mem_write),
        .swap_q     (swap_q),
        .busy       (busy),
        .done       (done)
    );

    ethdma_swap_lane u_wlane (.din(dev_wdata), .swap_en(swap_q), .dout(mem_wdata));
    ethdma_swap_lane u_rlane (.din(mem_rdata), .swap_en(swap_q), .dout(dev_rdata));

    assign dev_wtake  = mem_valid && mem_ready && mem_write;
    assign dev_rvalid = mem_valid && mem_ready && !mem_write;
endmodule

// File: rtl/ethdma_swap_path_chk.sv
module ethdma_swap_path_chk #(
    parameter int AW          = 32,
    parameter int CHUNK_BYTES = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_bypass,
    input logic          busy,
    input logic          done,
    input logic          dev_rvalid,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_be,
    input logic          mem_last
);
    logic        byp_q, wr_q;
    logic [15:0] beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q   <= 1'b0;
            wr_q    <= 1'b0;
            beats_q <= '0;
        end else if (req_valid && !busy) begin
            byp_q   <= req_bypass;
            wr_q    <= req_write;
            beats_q <= '0;
        end else if (mem_valid && mem_ready) begin
            beats_q <= mem_last ? '0 : beats_q + 16'd1;
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
    p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !byp_q) |-> (!mem_addr[0] && mem_be == 2'b11));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_last) |=>
        (mem_valid && mem_addr == $past(mem_addr) + AW'(2)));
    p_chunk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !byp_q && wr_q) |->
        (beats_q < 16'(CHUNK_BYTES / 2)));
    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rvalid |-> (mem_valid && mem_ready && !mem_write));
endmodule

bind ethdma_swap_path ethdma_swap_path_chk #(.AW(AW), .CHUNK_BYTES(CHUNK_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_bypass (req_bypass),
    .busy       (busy),
    .done       (done),
    .dev_rvalid (dev_rvalid),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_last   (mem_last)
);

// File: tb/ethdma_swap_path_bench.sv
`timescale 1ns/1ps
module ethdma_swap_path_bench;
    localparam int AW = 32;
    localparam int LW = 12;
    localparam int CH = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_write = 1'b0;
    logic          req_bypass = 1'b0;
    logic          busy, done;
    logic [15:0]   dev_wdata = '0;
    logic          dev_wtake;
    logic [15:0]   dev_rdata;
    logic          dev_rvalid;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic          mem_write;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_be;
    logic          mem_last;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int stall_ctr = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ethdma_swap_path #(.AW(AW), .LW(LW), .CHUNK_BYTES(CH)) u_ethdma_swap_path (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] wpat(input int k, input int seed);
        return {8'(k * 3 + seed), 8'(k * 7 + 8'h21 + seed)};
    endfunction

    function automatic logic [15:0] rpat(input logic [31:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] + a[7:0] + 8'h11};
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] base, input int len,
                       input bit we, input bit byp, input bit hammer);
        logic [31:0] a0;
        int          elen, p, k, guard, bl, seed;
        bit          gap_next, cend, lastb;
        logic [15:0] w, r, expd;
        logic [1:0]  ebe;
        a0   = a | base;
        elen = len;
        if (!byp) begin
            a0[0] = 1'b0;
            elen  = len & ~1;
        end
        seed = len + int'(a[3:0]);
        @(negedge clk);
        base_addr  = base;
        req_addr   = a;
        req_len    = LW'(len);
        req_write  = we;
        req_bypass = byp;
        req_valid  = 1'b1;
        @(negedge clk);
        // R8: conflicting request held during the transfer when hammering
        req_valid  = hammer;
        req_addr   = ~a;
        req_len    = LW'(7);
        req_bypass = ~byp;
        req_write  = ~we;
        chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
        if (elen == 0) begin
            chk(done == 1'b1 && mem_valid == 1'b0, "R6 zero length done", {62'd0, done, mem_valid}, 64'd2);
            req_valid = 1'b0;
            @(negedge clk);
            chk(!done && !busy, "R7 idle after zero length", {62'd0, done, busy}, 64'd0);
            return;
        end
        p = 0; k = 0; guard = 0; gap_next = 1'b0;
        while (p < elen && guard < 4000) begin
            w         = wpat(k, seed);
            dev_wdata = w;
            mem_ready = (stall_ctr % 4) != 3;
            stall_ctr++;
            r         = rpat(a0 + 32'(p));
            mem_rdata = r;
            #1;
            if (gap_next) begin
                chk(!mem_valid, "R5 gap cycle between chunks", 64'(mem_valid), 64'd0);
                gap_next = 1'b0;
            end else begin
                ebe   = (elen - p == 1) ? 2'b01 : 2'b11;
                lastb = (elen - p) <= 2;
                cend  = !byp && we && ((p % CH) + 2 == CH);
                chk(mem_valid, "R7 beat present while busy", 64'(mem_valid), 64'd1);
                chk(mem_addr == a0 + 32'(p), "R1 beat address", 64'(mem_addr), 64'(a0 + 32'(p)));
                chk(mem_be == ebe, "R2 byte enables", 64'(mem_be), 64'(ebe));
                chk(mem_last == (lastb || cend), "R5 burst end flag", 64'(mem_last), 64'(lastb || cend));
                chk(mem_write == we, "R9 direction", 64'(mem_write), 64'(we));
                if (mem_ready) begin
                    if (we) begin
                        expd = byp ? w : {w[7:0], w[15:8]};
                        chk(dev_wtake && !dev_rvalid, "R9 write take strobe", {62'd0, dev_wtake, dev_rvalid}, 64'd2);
                        chk(mem_wdata == expd, byp ? "R2 write data unchanged" : "R4 write data swapped",
                            64'(mem_wdata), 64'(expd));
                    end else begin
                        expd = byp ? r : {r[7:0], r[15:8]};
                        chk(dev_rvalid && !dev_wtake, "R9 read valid strobe", {62'd0, dev_rvalid, dev_wtake}, 64'd2);
                        chk(dev_rdata == expd, byp ? "R2 read data unchanged" : "R4 read data swapped",
                            64'(dev_rdata), 64'(expd));
                    end
                    bl = (elen - p == 1) ? 1 : 2;
                    p  = p + bl;
                    k++;
                    if (cend && !lastb) gap_next = 1'b1;
                end else begin
                    chk(!dev_wtake && !dev_rvalid, "R9 no strobe while stalled", {62'd0, dev_wtake, dev_rvalid}, 64'd0);
                end
            end
            @(negedge clk);
            guard++;
        end
        mem_ready = 1'b0;
        req_valid = 1'b0;
        chk(done && busy && !mem_valid, "R7 done after final beat", {61'd0, done, busy, mem_valid}, 64'd6);
        @(negedge clk);
        chk(!done && !busy, "R7 done single cycle", {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lens[10];
        lens = '{0, 1, 2, 3, 5, 62, 64, 66, 128, 131};
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_valid, "R7 reset state", {61'd0, busy, done, mem_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            for (int byp = 0; byp < 2; byp++) begin
                for (int we = 0; we < 2; we++) begin
                    for (int li = 0; li < 10; li++) begin
                        for (int odd = 0; odd < 2; odd++) begin
                            run(32'h0000_0200 + 32'(odd) + 32'(li * 4),
                                b ? 32'h00FF_0000 : 32'h0010_0000,
                                lens[li], we[0], byp[0], odd[0]);
                        end
                    end
                end
            end
        end
        // R3: base bits overlapping the address are ORed, not added
        run(32'h0000_0013, 32'h0000_0031, 6, 1'b1, 1'b0, 1'b0);
        run(32'h0000_0013, 32'h0000_0031, 5, 1'b0, 1'b1, 1'b1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule